// File: doc/BRIEF.md
# Sweep Point Settle-and-Sample Sequencer

This block paces a stepped-frequency measurement one sweep point at a time. An external table holds a configuration word for every point. The block presents the current point index and reads back that point's word, which carries a halt flag and a sample-count code. It raises a stimulus-active output, waits a programmable settling interval, and opens an ADC sample gate for a power-of-two number of cycles. It then signals that the point is complete and moves to the next index. After the last point it returns to idle and flags the end of the sweep.

A point marked to halt parks the sequencer before any settling or sampling until a resume command arrives. The settling interval is a 20-bit cycle count, split across two 16-bit registers. The lower register holds the low 16 bits. The upper register holds the top four bits in its least significant nibble, and all of its other bits read as zero. The interval is captured when settling begins, so a register write takes effect from the next point onward. A start input restarts the sweep at index zero from any state. A stop input returns the block to idle from any state and takes priority over start.

Every point runs through a one-cycle load state, an optional halt wait, settling, sampling and a one-cycle done state.

Top module: `sweepSequencer`

## Requirements
- R1: A write to address 0x14 sets settling-delay bits [15:0]. A write to address 0x15 sets bits [19:16] from write-data bits [3:0]. Reading 0x14 returns the low part. Reading 0x15 returns the high nibble in bits [3:0] with bits [15:4] zero. Any other address reads zero and ignores writes.
- R2: In the configuration word, bit 0 is the halt flag and bits [3:1] are the sample code. For a code c, sampleGate stays high for exactly 16 × 2^c consecutive cycles.
- R3: With settling delay D, sampleGate rises exactly D+1 cycles after stimOn rises, and stimOn stays high through sampling. With D = 0, sampling starts on the cycle right after stimOn rises.
- R4: For a point whose halt flag is set, halted stays high and stimOn stays low until resumeCmd is sampled high. stimOn is then high in the next cycle.
- R5: A resumeCmd that arrives while halted is low is neither acted on nor remembered. A later halting point still waits for a fresh resume, and the settling timing is unchanged.
- R6: pointDone is a one-cycle pulse in the cycle after the last sample cycle. Points are visited in order from index 0 up to lastIdx, and pointIdx equals the index of the point being processed.
- R7: sweepDone is high together with pointDone for the point at lastIdx, and busy is low in the next cycle.
- R8: sweepStart, when sweepStop is low, restarts the sequence at pointIdx 0 from any state, including in the middle of a sweep.
- R9: sweepStop returns the block to idle in the next cycle from any state, with busy, stimOn and sampleGate low. When sweepStart and sweepStop are high together, sweepStop wins.
- R10: The settling delay is captured when settling begins. A register write made during settling does not change the current point's timing, and it applies to the following points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr (combinational) |
| sweepStart | input | 1 | Start the sweep at point 0 |
| sweepStop | input | 1 | Abort to idle |
| resumeCmd | input | 1 | Release a halted point |
| lastIdx | input | 8 | Index of the final point |
| pointCfg | input | 4 | Configuration word of point pointIdx: bit 0 halt, bits [3:1] sample code |
| pointIdx | output | 8 | Current point index |
| stimOn | output | 1 | Stimulus active (settling and sampling) |
| sampleGate | output | 1 | ADC sample gate |
| halted | output | 1 | Waiting for resume |
| pointDone | output | 1 | Point complete pulse |
| sweepDone | output | 1 | Last point complete pulse |
| busy | output | 1 | Not idle |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a register write to the delay and the start of settling: the bench pokes address 0x14 in the first settling cycle of a point. It then requires the current point to keep the old D+1 spacing and the later points to follow the new value. The second pair is start and stop: the bench raises both in one idle cycle and requires busy to stay low. It also drives a resume during settling of a non-halting point and during idle, and requires the timing to be unchanged and the next halting point to still wait.

// File: rtl/sweepSeqPkg.sv
package sweepSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_HALT,
    ST_SETTLE,
    ST_SAMPLE,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic latchCfg;
    logic loadSettle;
    logic decSettle;
    logic loadSample;
    logic decSample;
  } seqStrobes_t;

endpackage

// File: rtl/sweepSeqDatapath.sv
module sweepSeqDatapath
  import sweepSeqPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int DELAY_W   = 20,
  parameter int IDX_W     = 8,
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h15
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [CODE_W-1:0] cfgCode,
  input  logic [IDX_W-1:0]  lastIdx,
  output logic [IDX_W-1:0]  pointIdx,
  output logic              settleZero,
  output logic              sampleZero,
  output logic              lastPoint
);

  localparam int HI_W  = DELAY_W - DATA_W;
  localparam int SMP_W = BASE_LOG2 + (1 << CODE_W) - 1;

  logic [DATA_W-1:0]  delayLo;
  logic [HI_W-1:0]    delayHi;
  logic [DELAY_W-1:0] settleCnt;
  logic [SMP_W-1:0]   sampleCnt;
  logic [CODE_W-1:0]  codeHeld;
  logic [SMP_W-1:0]   sampleLast;

  // delay registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayLo <= '0;
      delayHi <= '0;
    end else if (regWrEn) begin
      if (regAddr == LO_ADDR) delayLo <= regWrData;
      if (regAddr == HI_ADDR) delayHi <= regWrData[HI_W-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == LO_ADDR) regRdData = delayLo;
    else if (regAddr == HI_ADDR) regRdData = {{(DATA_W-HI_W){1'b0}}, delayHi};
  end

  // point index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pointIdx <= '0;
    else if (strobes.clrIdx) pointIdx <= '0;
    else if (strobes.incIdx) pointIdx <= pointIdx + 1'b1;
  end

  assign lastPoint = (pointIdx == lastIdx);

  // sample code captured once per point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) codeHeld <= '0;
    else if (strobes.latchCfg) codeHeld <= cfgCode;
  end

  // count - 1 for 2^(BASE_LOG2+code) samples
  assign sampleLast = {SMP_W{1'b1}} >> (SMP_W - BASE_LOG2 - int'(codeHeld));

  // settle counter: delay captured at entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settleCnt <= '0;
    else if (strobes.loadSettle) settleCnt <= {delayHi, delayLo};
    else if (strobes.decSettle) settleCnt <= settleCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleCnt <= '0;
    else if (strobes.loadSample) sampleCnt <= sampleLast;
    else if (strobes.decSample) sampleCnt <= sampleCnt - 1'b1;
  end

  assign settleZero = (settleCnt == '0);
  assign sampleZero = (sampleCnt == '0);

endmodule

// File: rtl/sweepSeqControl.sv
module sweepSeqControl
  import sweepSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sweepStart,
  input  logic        sweepStop,
  input  logic        resumeCmd,
  input  logic        cfgHalt,
  input  logic        settleZero,
  input  logic        sampleZero,
  input  logic        lastPoint,
  output seqStrobes_t strobes,
  output logic        stimOn,
  output logic        sampleGate,
  output logic        halted,
  output logic        pointDone,
  output logic        sweepDone,
  output logic        busy
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    if (sweepStop) begin
      nextState = ST_IDLE;
    end else if (sweepStart) begin
      nextState      = ST_LOAD;
      strobes.clrIdx = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_LOAD: begin
          strobes.latchCfg = 1'b1;
          if (cfgHalt) begin
            nextState = ST_HALT;
          end else begin
            nextState          = ST_SETTLE;
            strobes.loadSettle = 1'b1;
          end
        end
        ST_HALT: begin
          if (resumeCmd) begin
            nextState          = ST_SETTLE;
            strobes.loadSettle = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settleZero) begin
            nextState          = ST_SAMPLE;
            strobes.loadSample = 1'b1;
          end else begin
            strobes.decSettle = 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (sampleZero) nextState = ST_DONE;
          else strobes.decSample = 1'b1;
        end
        ST_DONE: begin
          if (lastPoint) begin
            nextState = ST_IDLE;
          end else begin
            nextState      = ST_LOAD;
            strobes.incIdx = 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign stimOn     = (state == ST_SETTLE) || (state == ST_SAMPLE);
  assign sampleGate = (state == ST_SAMPLE);
  assign halted     = (state == ST_HALT);
  assign pointDone  = (state == ST_DONE);
  assign sweepDone  = (state == ST_DONE) && lastPoint;
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/sweepSequencer.sv
module sweepSequencer
  import sweepSeqPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int DELAY_W   = 20,
  parameter int IDX_W     = 8,
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sweepStart,
  input  logic              sweepStop,
  input  logic              resumeCmd,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic [CODE_W:0]   pointCfg,
  output logic [IDX_W-1:0]  pointIdx,
  output logic              stimOn,
  output logic              sampleGate,
  output logic              halted,
  output logic              pointDone,
  output logic              sweepDone,
  output logic              busy
);

  seqStrobes_t strobes;
  logic settleZero, sampleZero, lastPoint;

  sweepSeqControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sweepStart (sweepStart),
    .sweepStop  (sweepStop),
    .resumeCmd  (resumeCmd),
    .cfgHalt    (pointCfg[0]),
    .settleZero (settleZero),
    .sampleZero (sampleZero),
    .lastPoint  (lastPoint),
    .strobes    (strobes),
    .stimOn     (stimOn),
    .sampleGate (sampleGate),
    .halted     (halted),
    .pointDone  (pointDone),
    .sweepDone  (sweepDone),
    .busy       (busy)
  );

  sweepSeqDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DELAY_W   (DELAY_W),
    .IDX_W     (IDX_W),
    .CODE_W    (CODE_W),
    .BASE_LOG2 (BASE_LOG2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .cfgCode    (pointCfg[CODE_W:1]),
    .lastIdx    (lastIdx),
    .pointIdx   (pointIdx),
    .settleZero (settleZero),
    .sampleZero (sampleZero),
    .lastPoint  (lastPoint)
  );

endmodule

// File: rtl/sweepSequencerChk.sv
module sweepSequencerChk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int HI_W   = 4,
  parameter int IDX_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h15
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              sweepStart,
  input logic              sweepStop,
  input logic              resumeCmd,
  input logic [IDX_W-1:0]  pointIdx,
  input logic              stimOn,
  input logic              sampleGate,
  input logic              halted,
  input logic              pointDone,
  input logic              sweepDone,
  input logic              busy
);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == HI_ADDR) |-> ((regRdData >> HI_W) == '0)); // R1

  AST_GATE_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sampleGate) && !$past(sweepStop) && !$past(sweepStart)) |-> pointDone); // R2

  AST_GATE_UNDER_STIM: assert property (@(posedge clk) disable iff (!rstN)
    sampleGate |-> stimOn); // R3

  AST_HALT_NO_STIM: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !stimOn); // R4

  AST_RESUME_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (halted && resumeCmd && !sweepStop && !sweepStart) |=> (stimOn && !halted)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pointDone |=> !pointDone); // R6

  AST_SWEEP_WITH_POINT: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> pointDone); // R7

  AST_SWEEP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (sweepDone && !sweepStart) |=> !busy); // R7

  AST_START_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (sweepStart && !sweepStop) |=> (pointIdx == '0 && busy)); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    sweepStop |=> (!busy && !stimOn && !sampleGate)); // R9

endmodule

bind sweepSequencer sweepSequencerChk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .HI_W   (DELAY_W - DATA_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regRdData  (regRdData),
  .sweepStart (sweepStart),
  .sweepStop  (sweepStop),
  .resumeCmd  (resumeCmd),
  .pointIdx   (pointIdx),
  .stimOn     (stimOn),
  .sampleGate (sampleGate),
  .halted     (halted),
  .pointDone  (pointDone),
  .sweepDone  (sweepDone),
  .busy       (busy)
);

// File: tb/test_sweepSequencer.sv
`timescale 1ns/1ps
module test_sweepSequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        sweepStart = 1'b0;
  logic        sweepStop = 1'b0;
  logic        resumeCmd = 1'b0;
  logic [7:0]  lastIdx = '0;
  logic [3:0]  pointCfg;
  logic [7:0]  pointIdx;
  logic        stimOn, sampleGate, halted, pointDone, sweepDone, busy;

  logic [3:0]  cfgMem [16];
  int          checks = 0;
  int          fails = 0;
  int          curDelay = 0;

  assign pointCfg = cfgMem[pointIdx[3:0]];

  always #5 clk = ~clk;

  sweepSequencer i_sweepSequencer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sweepStart(sweepStart),
    .sweepStop(sweepStop), .resumeCmd(resumeCmd), .lastIdx(lastIdx),
    .pointCfg(pointCfg), .pointIdx(pointIdx), .stimOn(stimOn),
    .sampleGate(sampleGate), .halted(halted), .pointDone(pointDone),
    .sweepDone(sweepDone), .busy(busy)
  );

  function automatic int expSamples(input logic [3:0] cfg);
    return 16 << cfg[3:1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setDelay(input int d);
    writeReg(8'h14, d[15:0]);
    writeReg(8'h15, {12'h000, d[19:16]});
    curDelay = d;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    sweepStart = 1'b1;
    @(negedge clk);
    sweepStart = 1'b0;
  endtask

  // entered at the negedge where the block is in its load state for point 0
  task automatic monitorSweep(input int last, input bit poke, input int pokeVal);
    int s, n, dExp;
    for (int p = 0; p <= last; p++) begin
      chk(pointIdx == p[7:0], "R6 index", pointIdx, p);
      dExp = curDelay;
      if (cfgMem[p][0]) begin
        @(negedge clk);
        chk(halted && !stimOn, "R4 halt entry", {halted, stimOn}, 2);
        repeat (3) @(negedge clk);
        chk(halted && !stimOn, "R4 halt held", {halted, stimOn}, 2);
        resumeCmd = 1'b1;
        @(negedge clk);
        resumeCmd = 1'b0;
        chk(stimOn == 1'b1, "R4 resume", stimOn, 1);
      end else begin
        @(negedge clk);
        resumeCmd = 1'b1; // R5: stray resume during settling
      end
      s = 0;
      while (!sampleGate) begin
        chk(stimOn == 1'b1, "R3 stim during settle", stimOn, 1);
        if (poke && p == 0 && s == 0) begin
          regWrEn = 1'b1; regAddr = 8'h14; regWrData = pokeVal[15:0];
        end
        s++;
        @(negedge clk);
        resumeCmd = 1'b0;
        regWrEn = 1'b0;
      end
      if (poke && p == 0) curDelay = (curDelay & 32'hF0000) | (pokeVal & 32'hFFFF);
      chk(s == dExp + 1, "R3 R10 settle cycles", s, dExp + 1);
      n = 0;
      while (sampleGate) begin
        chk(stimOn == 1'b1, "R3 stim during sample", stimOn, 1);
        n++;
        @(negedge clk);
      end
      chk(n == expSamples(cfgMem[p]), "R2 sample count", n, expSamples(cfgMem[p]));
      chk(pointDone == 1'b1, "R6 point done", pointDone, 1);
      chk(sweepDone == (p == last), "R7 sweep done", sweepDone, p == last);
      @(negedge clk);
      chk(pointDone == 1'b0, "R6 done one cycle", pointDone, 0);
    end
    chk(busy == 1'b0, "R7 idle after sweep", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) cfgMem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk(!busy && !stimOn && !sampleGate && !halted, "R9 reset idle", busy, 0);
    regAddr = 8'h14; #1;
    chk(regRdData == 16'h0, "R1 reset low", regRdData, 0);

    // R1 register map
    writeReg(8'h14, 16'hA5C3);
    writeReg(8'h15, 16'hFFFF);
    writeReg(8'h30, 16'h1234);
    regAddr = 8'h14; #1;
    chk(regRdData == 16'hA5C3, "R1 low readback", regRdData, 16'hA5C3);
    regAddr = 8'h15; #1;
    chk(regRdData == 16'h000F, "R1 reserved zero", regRdData, 16'h000F);
    regAddr = 8'h30; #1;
    chk(regRdData == 16'h0, "R1 unmapped", regRdData, 0);

    // R3 zero delay, R2 code 0, R5 resume while idle
    setDelay(0);
    cfgMem[0] = 4'b0000;
    cfgMem[1] = 4'b0001; // halt, code 0
    lastIdx = 8'd1;
    @(negedge clk); resumeCmd = 1'b1;
    @(negedge clk); resumeCmd = 1'b0;
    pulseStart();
    monitorSweep(1, 1'b0, 0);

    // R2 largest code, R10 write during settle
    setDelay(20);
    cfgMem[0] = 4'b1110;
    cfgMem[1] = 4'b0100;
    cfgMem[2] = 4'b0011;
    lastIdx = 8'd2;
    pulseStart();
    monitorSweep(2, 1'b1, 7);

    // R3 delay using the upper nibble
    setDelay(20'h10005);
    cfgMem[0] = 4'b0000;
    lastIdx = 8'd0;
    pulseStart();
    monitorSweep(0, 1'b0, 0);

    // random sweeps
    for (int k = 0; k < 5; k++) begin
      int last;
      last = 1 + int'($urandom_range(3));
      for (int i = 0; i <= last; i++)
        cfgMem[i] = {3'($urandom_range(6)), 1'($urandom_range(1))};
      setDelay(int'($urandom_range(150)));
      lastIdx = last[7:0];
      pulseStart();
      monitorSweep(last, 1'b0, 0);
    end

    // R9 stop during sampling
    setDelay(3);
    cfgMem[0] = 4'b0110; cfgMem[1] = 4'b0000;
    lastIdx = 8'd1;
    pulseStart();
    repeat (10) @(negedge clk);
    chk(sampleGate == 1'b1, "R9 in sampling", sampleGate, 1);
    sweepStop = 1'b1;
    @(negedge clk);
    sweepStop = 1'b0;
    chk(!busy && !stimOn && !sampleGate, "R9 stop abort", busy, 0);

    // R9 stop during halt
    cfgMem[0] = 4'b0001;
    pulseStart();
    @(negedge clk);
    chk(halted == 1'b1, "R4 halted before stop", halted, 1);
    sweepStop = 1'b1;
    @(negedge clk);
    sweepStop = 1'b0;
    chk(!busy && !halted, "R9 stop from halt", busy, 0);

    // R9 start and stop together
    @(negedge clk);
    sweepStart = 1'b1; sweepStop = 1'b1;
    @(negedge clk);
    sweepStart = 1'b0; sweepStop = 1'b0;
    chk(busy == 1'b0, "R9 stop wins", busy, 1'b0);

    // R8 restart mid-sweep
    cfgMem[0] = 4'b0000; cfgMem[1] = 4'b0010;
    setDelay(2);
    pulseStart();
    while (pointIdx != 8'd1) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(busy == 1'b1, "R8 mid sweep", busy, 1);
    pulseStart();
    chk(pointIdx == 8'd0 && busy, "R8 restart index", pointIdx, 0);
    monitorSweep(1, 1'b0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule